// File: doc/BRIEF.md
# Backup Cache Bypass Request Router

This block sits at the front of a bus interface unit. It decides, for each read or write reference, whether the reference should try the external backup cache or go straight to the system bus. The router accepts one reference at a time. The two most significant physical address bits select one of four quadrants of the physical address space. A global cache-enable bit and a four-bit per-quadrant disable mask then decide the route. A cacheable reference is handed to the tag lookup stage as a probe request. Any other reference goes to the system interface as a request, and no probe is ever made for it.

Software programs the enable bit and the mask through a small configuration write port. Each field has its own write strobe. Reset clears the enable bit, so every reference bypasses the cache until software turns it on. Reset leaves the mask alone: it keeps whatever was last written, and it is undefined until the first write.

The mask only steers references away from the backup cache. It does not decide what the primary caches may hold. Reads and writes follow the same rule, and the read/write flag passes through unchanged.

Top module: `bc_bypass_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1 and both `prb_valid` and `sys_valid` are 0.
- R2: The quadrant is `req_addr[33:32]`. A reference accepted while the enable bit is 1 and mask bit [quadrant] is 0 appears on the probe port in the cycle after acceptance, with its address unchanged. `sys_valid` stays 0 for that reference.
- R3: A reference accepted while the enable bit is 0, or while mask bit [quadrant] is 1, appears on the system port in the cycle after acceptance, with its address unchanged. `prb_valid` is never asserted for it. The two valid outputs are never 1 together.
- R4: A forwarded request holds its valid output, address and write flag stable until the matching ready input is sampled high.
- R5: `req_ready` is 0 from the cycle after a reference is accepted until the cycle after its forwarded handshake completes. It is 1 again in that cycle.
- R6: `req_write` (1 = write, 0 = read) is carried unchanged to whichever output port is used. Reads and writes are routed by the same rule.
- R7: `cfg_wr_en` loads `cfg_en_in` and `cfg_wr_mask` loads `cfg_mask_in` at the clock edge. A reference accepted at that same edge is routed with the configuration held before the write.
- R8: Reset clears the enable bit but not the mask. A mask written before reset still governs routing after the enable bit is written again on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Strobe that loads the global enable bit |
| cfg_wr_mask | input | 1 | Strobe that loads the quadrant disable mask |
| cfg_en_in | input | 1 | New global enable value |
| cfg_mask_in | input | 4 | New disable mask; bit i disables quadrant i |
| req_valid | input | 1 | Incoming reference valid |
| req_ready | output | 1 | Router can accept a reference |
| req_addr | input | 34 | Physical address of the reference |
| req_write | input | 1 | 1 = write, 0 = read |
| prb_valid | output | 1 | Tag probe request valid |
| prb_ready | input | 1 | Tag lookup stage accepts the probe |
| prb_addr | output | 34 | Probe address |
| prb_write | output | 1 | Probe read/write flag |
| sys_valid | output | 1 | System request valid |
| sys_ready | input | 1 | System interface accepts the request |
| sys_addr | output | 34 | System request address |
| sys_write | output | 1 | System request read/write flag |

## Verification
The hardest case to reach from the ports is a mask that outlives reset. The bench loads a mask and enables the cache, then pulses reset. It then writes the enable bit alone while driving a different value on the mask input, and probes several quadrants to show that the old mask still routes them. A second hard case is a configuration write at the same edge as an acceptance. The bench raises both strobes in one cycle and expects the old route. Around these cases, the bench sweeps every mask value, every quadrant, both enable states and both directions. It varies the output stall length so that holding is checked too.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_SYS   = 2'd2
    } route_e;
endpackage

// File: rtl/bcr_cfg_reg.sv
module bcr_cfg_reg #(
    parameter int NQ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_mask,
    input  logic          en_in,
    input  logic [NQ-1:0] mask_in,
    output logic          en_q,
    output logic [NQ-1:0] mask_q
);
    logic          en_d;
    logic [NQ-1:0] mask_d;

    always_comb begin
        en_d   = wr_en   ? en_in   : en_q;
        mask_d = wr_mask ? mask_in : mask_q;
    end

    // enable bit: cleared by reset so the cache starts off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    // mask: deliberately left out of reset
    always_ff @(posedge clk) begin
        mask_q <= mask_d;
    end
endmodule

// File: rtl/bcr_quad_decide.sv
module bcr_quad_decide #(
    parameter int QSEL_W = 2,
    localparam int NQ = 1 << QSEL_W
) (
    input  logic [QSEL_W-1:0] quad,
    input  logic              en,
    input  logic [NQ-1:0]     mask,
    output logic              use_cache
);
    logic [NQ-1:0] open_hit;

    generate
        for (genvar i = 0; i < NQ; i++) begin : g_quad
            assign open_hit[i] = (quad == QSEL_W'(i)) && !mask[i];
        end
    endgenerate

    always_comb begin
        use_cache = en && (|open_hit);
    end
endmodule

// File: rtl/bcr_seq.sv
module bcr_seq
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              use_cache,
    output logic              prb_valid,
    input  logic              prb_ready,
    output logic              sys_valid,
    input  logic              sys_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write
);
    typedef struct packed {
        route_e            st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st   = use_cache ? ST_PROBE : ST_SYS;
                    s_d.addr = req_addr;
                    s_d.wr   = req_write;
                end
            end
            ST_PROBE: if (prb_ready) s_d.st = ST_IDLE;
            ST_SYS:   if (sys_ready) s_d.st = ST_IDLE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, addr: '0, wr: 1'b0};
        else        s_q <= s_d;
    end

    always_comb begin
        req_ready = (s_q.st == ST_IDLE);
        prb_valid = (s_q.st == ST_PROBE);
        sys_valid = (s_q.st == ST_SYS);
        out_addr  = s_q.addr;
        out_write = s_q.wr;
    end
endmodule

// File: rtl/bc_bypass_router.sv
module bc_bypass_router #(
    parameter int ADDR_W = 34,
    parameter int QSEL_W = 2,
    localparam int NQ = 1 << QSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_mask,
    input  logic              cfg_en_in,
    input  logic [NQ-1:0]     cfg_mask_in,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              prb_valid,
    input  logic              prb_ready,
    output logic [ADDR_W-1:0] prb_addr,
    output logic              prb_write,
    output logic              sys_valid,
    input  logic              sys_ready,
    output logic [ADDR_W-1:0] sys_addr,
    output logic              sys_write
);
    logic              en_q;
    logic [NQ-1:0]     mask_q;
    logic              use_cache;
    logic [ADDR_W-1:0] fwd_addr;
    logic              fwd_write;

    bcr_cfg_reg #(.NQ(NQ)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_mask (cfg_wr_mask),
        .en_in   (cfg_en_in),
        .mask_in (cfg_mask_in),
        .en_q    (en_q),
        .mask_q  (mask_q)
    );

    bcr_quad_decide #(.QSEL_W(QSEL_W)) i_decide (
        .quad      (req_addr[ADDR_W-1 -: QSEL_W]),
        .en        (en_q),
        .mask      (mask_q),
        .use_cache (use_cache)
    );

    bcr_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_write (req_write),
        .use_cache (use_cache),
        .prb_valid (prb_valid),
        .prb_ready (prb_ready),
        .sys_valid (sys_valid),
        .sys_ready (sys_ready),
        .out_addr  (fwd_addr),
        .out_write (fwd_write)
    );

    always_comb begin
        prb_addr  = fwd_addr;
        prb_write = fwd_write;
        sys_addr  = fwd_addr;
        sys_write = fwd_write;
    end
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
    parameter int ADDR_W = 34,
    parameter int QSEL_W = 2,
    localparam int NQ = 1 << QSEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic              cfg_wr_mask,
    input logic              cfg_en_in,
    input logic [NQ-1:0]     cfg_mask_in,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              prb_valid,
    input logic              prb_ready,
    input logic [ADDR_W-1:0] prb_addr,
    input logic              prb_write,
    input logic              sys_valid,
    input logic              sys_ready,
    input logic [ADDR_W-1:0] sys_addr,
    input logic              sys_write
);
    // shadow of the configuration, rebuilt from the write port
    logic          en_s;
    logic [NQ-1:0] mask_s;
    logic          mask_known = 1'b0;
    logic          acc;
    logic [QSEL_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         en_s <= 1'b0;
        else if (cfg_wr_en) en_s <= cfg_en_in;
    end

    always_ff @(posedge clk) begin
        if (cfg_wr_mask) begin
            mask_s     <= cfg_mask_in;
            mask_known <= 1'b1;
        end
    end

    assign acc = req_valid && req_ready;
    assign q   = req_addr[ADDR_W-1 -: QSEL_W];

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !prb_valid && !sys_valid));

    assert_probe_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && en_s && mask_known && !mask_s[q]) |=>
            (prb_valid && !sys_valid && prb_addr == $past(req_addr)));

    assert_bypass_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (!en_s || (mask_known && mask_s[q]))) |=>
            (sys_valid && !prb_valid && sys_addr == $past(req_addr)));

    assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(prb_valid && sys_valid));

    assert_probe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_valid && !prb_ready) |=>
            (prb_valid && $stable(prb_addr) && $stable(prb_write)));

    assert_sys_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_valid && !sys_ready) |=>
            (sys_valid && $stable(sys_addr) && $stable(sys_write)));

    assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_valid || sys_valid) |-> !req_ready);

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((prb_valid && prb_ready) || (sys_valid && sys_ready)) |=> req_ready);

    assert_write_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ((prb_valid ? prb_write : sys_write) == $past(req_write)));
endmodule

bind bc_bypass_router bcr_checker #(.ADDR_W(ADDR_W), .QSEL_W(QSEL_W)) i_bcr_checker (.*);

// File: tb/test_bc_bypass_router.sv
module test_bc_bypass_router;
    localparam int ADDR_W = 34;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic              cfg_wr_mask = 1'b0;
    logic              cfg_en_in = 1'b0;
    logic [3:0]        cfg_mask_in = 4'h0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              prb_valid;
    logic              prb_ready = 1'b0;
    logic [ADDR_W-1:0] prb_addr;
    logic              prb_write;
    logic              sys_valid;
    logic              sys_ready = 1'b0;
    logic [ADDR_W-1:0] sys_addr;
    logic              sys_write;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    bc_bypass_router i_bc_bypass_router (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic cfg_write(input bit we_en, input bit we_mask, input bit en, input logic [3:0] mask);
        @(negedge clk);
        cfg_wr_en = we_en; cfg_wr_mask = we_mask; cfg_en_in = en; cfg_mask_in = mask;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_mask = 1'b0;
    endtask

    // forward the pending output after 'stall' cycles and check idle afterwards
    task automatic finish_req(input bit to_probe, input logic [ADDR_W-1:0] a, input bit wr, input int stall);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk((to_probe ? prb_valid : sys_valid) === 1'b1, "R4 valid held",
                to_probe ? prb_valid : sys_valid, 1);
            chk((to_probe ? prb_addr : sys_addr) === a, "R4 addr held",
                to_probe ? prb_addr : sys_addr, a);
            chk(req_ready === 1'b0, "R5 busy", req_ready, 0);
        end
        if (to_probe) prb_ready = 1'b1; else sys_ready = 1'b1;
        @(negedge clk);
        prb_ready = 1'b0; sys_ready = 1'b0;
        chk(req_ready === 1'b1 && prb_valid === 1'b0 && sys_valid === 1'b0, "R5 released",
            {req_ready, prb_valid, sys_valid}, 3'b100);
    endtask

    task automatic do_req(input logic [ADDR_W-1:0] a, input bit wr, input bit exp_probe, input int stall);
        @(negedge clk);
        chk(req_ready === 1'b1, "R5 ready before request", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_probe) begin
            chk(prb_valid === 1'b1 && sys_valid === 1'b0, "R2 probe route",
                {prb_valid, sys_valid}, 2'b10);
            chk(prb_addr === a, "R2 probe addr", prb_addr, a);
            chk(prb_write === wr, "R6 probe write flag", prb_write, wr);
        end else begin
            chk(sys_valid === 1'b1 && prb_valid === 1'b0, "R3 bypass route",
                {prb_valid, sys_valid}, 2'b01);
            chk(sys_addr === a, "R3 system addr", sys_addr, a);
            chk(sys_write === wr, "R6 system write flag", sys_write, wr);
        end
        finish_req(exp_probe, a, wr, stall);
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int quad, input int idx);
        logic [31:0] low;
        low = 32'(idx) * 32'h9E37_79B9 + 32'h0000_1234;
        return {2'(quad), low};
    endfunction

    initial begin
        #600000;
        n_err++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int idx;
        bit exp_p;
        idx = 0;
        // R1: reset state
        @(negedge clk);
        chk(req_ready === 1'b1 && prb_valid === 1'b0 && sys_valid === 1'b0, "R1 in reset",
            {req_ready, prb_valid, sys_valid}, 3'b100);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && prb_valid === 1'b0 && sys_valid === 1'b0, "R1 after reset",
            {req_ready, prb_valid, sys_valid}, 3'b100);

        // R2/R3/R4/R6 sweep: every enable, mask, quadrant and direction
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 16; m++) begin
                cfg_write(1'b1, 1'b1, en[0], 4'(m));
                for (int q = 0; q < 4; q++) begin
                    for (int w = 0; w < 2; w++) begin
                        exp_p = (en == 1) && (((m >> q) & 1) == 0);
                        do_req(mk_addr(q, idx), w[0], exp_p, idx % 3);
                        idx++;
                    end
                end
            end
        end

        // R7: config write at the same edge as acceptance uses the old config
        cfg_write(1'b1, 1'b1, 1'b1, 4'b0000);
        @(negedge clk);
        req_valid = 1'b1; req_addr = mk_addr(0, 7); req_write = 1'b0;
        cfg_wr_en = 1'b1; cfg_en_in = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; cfg_wr_en = 1'b0;
        chk(prb_valid === 1'b1 && sys_valid === 1'b0, "R7 old config routes same-edge request",
            {prb_valid, sys_valid}, 2'b10);
        finish_req(1'b1, mk_addr(0, 7), 1'b0, 1);
        do_req(mk_addr(0, 8), 1'b1, 1'b0, 0);   // R7 new config (disabled) now applies
        // R7 mask write at same edge as acceptance
        cfg_write(1'b1, 1'b1, 1'b1, 4'b0000);
        @(negedge clk);
        req_valid = 1'b1; req_addr = mk_addr(2, 9); req_write = 1'b1;
        cfg_wr_mask = 1'b1; cfg_mask_in = 4'b0100;
        @(negedge clk);
        req_valid = 1'b0; cfg_wr_mask = 1'b0;
        chk(prb_valid === 1'b1, "R7 old mask routes same-edge request", prb_valid, 1);
        finish_req(1'b1, mk_addr(2, 9), 1'b1, 0);
        do_req(mk_addr(2, 10), 1'b1, 1'b0, 0);  // R7 new mask now applies

        // R8: mask survives reset, enable does not
        cfg_write(1'b1, 1'b1, 1'b1, 4'b0101);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && prb_valid === 1'b0 && sys_valid === 1'b0, "R1 after second reset",
            {req_ready, prb_valid, sys_valid}, 3'b100);
        do_req(mk_addr(1, 11), 1'b0, 1'b0, 0);  // R8 enable cleared by reset: bypass
        cfg_write(1'b1, 1'b0, 1'b1, 4'b1010);   // enable only; mask input ignored
        do_req(mk_addr(0, 12), 1'b0, 1'b0, 1);  // R8 quadrant 0 still disabled
        do_req(mk_addr(1, 13), 1'b1, 1'b1, 1);  // R8 quadrant 1 still open
        do_req(mk_addr(2, 14), 1'b0, 1'b0, 0);  // R8 quadrant 2 still disabled
        do_req(mk_addr(3, 15), 1'b1, 1'b1, 2);  // R8 quadrant 3 still open

        finish_run();
    end
endmodule